// File: doc/BRIEF.md
# Per-Bit Pulse/Level Output Port

This block drives a bank of output pins from a simple register-mapped bus slave. Each pin works in one of two modes. In level mode the pin holds whatever value was last written to the hold register. In pulse mode the pin ignores that held value. It goes high for a fixed number of clocks each time a 1 lands on its position in the strobe register. A mode register picks, for each pin, which of the two sources drives it. The two write paths share the same pins. Software can therefore mix held control lines and one-shot triggers on one port. A common use is to toggle a level bit high and then low, which makes a clean rising and falling edge for a loopback test of some input elsewhere.

The bus has a write strobe, a read strobe, a word address and 32-bit write and read data. Only the low `OUT_W` bits of write data are kept. Three word addresses are decoded: 2 is the mode register, 3 is the strobe register and 4 is the hold register. Reads of the mode and hold registers return their stored values one clock after the read strobe.

Each pin has its own small pulse engine. It is a two-state machine, `CH_IDLE` and `CH_HIGH`, with a down-counter:
- `CH_IDLE` goes to `CH_HIGH` on a fire. That is a strobe write with a 1 on a pulse-mode bit, and the counter loads `PULSE_W-1`.
- In `CH_HIGH`, a fire reloads the counter and the machine stays in `CH_HIGH`. This is the retrigger transition.
- In `CH_HIGH`, the machine returns to `CH_IDLE` when the counter reaches zero (the expire transition). It also returns to `CH_IDLE` when the pin leaves pulse mode (the abort transition).
- Otherwise `CH_HIGH` counts down.

Top module: `pulse_latch_port`

## Requirements
- R1: While reset is held, and after it is released with no writes, all pins are 0, both stored registers are 0, and reads return 0.
- R2: A read strobe at word 2 or word 4 returns the stored mode or hold value on `bus_rdata` in the cycle after the strobe. Bits 31:24 of that value are always 0, because write data bits above bit 23 are discarded.
- R3: A pin in level mode (mode bit 0) shows the hold register bit from the cycle after a write to word 4 until the next such write. Writing 1 and then 0 gives a rising edge and then a falling edge.
- R4: A write to word 3 with a 1 at position i, while mode bit i is 1, drives pin i high for exactly `PULSE_W` cycles. The pulse starts in the cycle after the write.
- R5: A write to word 3 has no effect on a pin whose data bit is 0 or whose mode bit is 0.
- R6: A pin in pulse mode ignores the hold register. The hold value is still stored and can be read back.
- R7: A write to word 3 that fires a pin already pulsing restarts its width. The pin then stays high for `PULSE_W` cycles after the new write, with no low gap.
- R8: Clearing a mode bit during a pulse ends that pulse. From the next cycle the pin shows the hold register bit, and the pin stays low if the mode bit is set again before any new strobe.
- R9: Writes to any word address other than 2, 3 or 4 change nothing. Reads from such addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W (6) | Word address |
| bus_wdata | input | DATA_W (32) | Write data; only the low OUT_W bits are used |
| bus_rdata | output | DATA_W (32) | Read data, valid the cycle after `bus_rd` |
| port_out | output | OUT_W (24) | Output pins |

## Verification
A new strobe write can arrive in the very cycle that a pin's counter reaches zero. This makes the retrigger and expire transitions compete. The bench provokes it by strobing the pin at its last high cycle and at other points of the pulse. It judges the result by counting how many cycles the pin stays high without a break. A mode write can also land while a pulse is running, which makes the abort compete with the ongoing count. A cycle-accurate arithmetic model in the bench tracks the remaining width of every bit, and pseudo-random sweeps over all 24 bits hit both collisions many times.

// File: rtl/plp_pkg.sv
package plp_pkg;
    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_HIGH = 1'b1
    } chan_state_e;

    localparam int unsigned WORD_MODE  = 2;
    localparam int unsigned WORD_PULSE = 3;
    localparam int unsigned WORD_LATCH = 4;
endpackage

// File: rtl/plp_regs.sv
module plp_regs
    import plp_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned OUT_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [OUT_W-1:0]  mode_q,
    output logic [OUT_W-1:0]  latch_q,
    output logic [OUT_W-1:0]  fire,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam int unsigned PAD_W = DATA_W - OUT_W;

    logic             hit_mode, hit_pulse, hit_latch;
    logic [OUT_W-1:0] wr_val;
    logic [OUT_W-1:0] rd_val;
    logic             unused_wdata_hi;

    assign hit_mode  = (bus_addr == ADDR_W'(WORD_MODE));
    assign hit_pulse = (bus_addr == ADDR_W'(WORD_PULSE));
    assign hit_latch = (bus_addr == ADDR_W'(WORD_LATCH));
    assign wr_val    = bus_wdata[OUT_W-1:0];
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:OUT_W];

    // Strobe decode: only pulse-mode positions carrying a 1 fire.
    assign fire = (bus_wr && hit_pulse) ? (wr_val & mode_q) : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= '0;
            latch_q <= '0;
        end else if (bus_wr) begin
            if (hit_mode)  mode_q  <= wr_val;
            if (hit_latch) latch_q <= wr_val;
        end
    end

    always_comb begin
        rd_val = '0;
        if (hit_mode)  rd_val = mode_q;
        if (hit_latch) rd_val = latch_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= {{PAD_W{1'b0}}, rd_val};
        end
    end
endmodule

// File: rtl/plp_pulse_chan.sv
module plp_pulse_chan
    import plp_pkg::*;
#(
    parameter int unsigned PULSE_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic fire,
    output logic active
);
    localparam int unsigned CNT_W = (PULSE_W > 1) ? $clog2(PULSE_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PULSE_W - 1);

    chan_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            CH_IDLE: begin
                if (fire && enable) begin
                    state_d = CH_HIGH;
                    cnt_d   = LAST;
                end
            end
            CH_HIGH: begin
                if (!enable) begin
                    state_d = CH_IDLE;
                    cnt_d   = '0;
                end else if (fire) begin
                    cnt_d   = LAST;
                end else if (cnt_q == '0) begin
                    state_d = CH_IDLE;
                end else begin
                    cnt_d   = cnt_q - 1'b1;
                end
            end
            default: begin
                state_d = CH_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        active = (state_q == CH_HIGH);
    end
endmodule

// File: rtl/pulse_latch_port.sv
module pulse_latch_port
    import plp_pkg::*;
#(
    parameter int unsigned ADDR_W  = 6,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned OUT_W   = 24,
    parameter int unsigned PULSE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [OUT_W-1:0]  port_out
);
    logic [OUT_W-1:0] mode_q;
    logic [OUT_W-1:0] latch_q;
    logic [OUT_W-1:0] fire;
    logic [OUT_W-1:0] pulse_act;

    plp_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .OUT_W  (OUT_W)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .mode_q    (mode_q),
        .latch_q   (latch_q),
        .fire      (fire),
        .bus_rdata (bus_rdata)
    );

    for (genvar i = 0; i < OUT_W; i++) begin : g_bit
        plp_pulse_chan #(
            .PULSE_W (PULSE_W)
        ) chan_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .enable (mode_q[i]),
            .fire   (fire[i]),
            .active (pulse_act[i])
        );

        assign port_out[i] = mode_q[i] ? pulse_act[i] : latch_q[i];
    end
endmodule

// File: rtl/pulse_latch_port_sva.sv
module pulse_latch_port_sva
    import plp_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned OUT_W  = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [OUT_W-1:0]  port_out,
    input logic [OUT_W-1:0]  mode_q,
    input logic [OUT_W-1:0]  latch_q
);
    logic             wr_mode, wr_pulse, wr_latch, rd_unmapped;
    logic [OUT_W-1:0] chk_fire;

    assign wr_mode     = bus_wr && (bus_addr == ADDR_W'(WORD_MODE));
    assign wr_pulse    = bus_wr && (bus_addr == ADDR_W'(WORD_PULSE));
    assign wr_latch    = bus_wr && (bus_addr == ADDR_W'(WORD_LATCH));
    assign rd_unmapped = bus_rd && (bus_addr != ADDR_W'(WORD_MODE))
                                && (bus_addr != ADDR_W'(WORD_LATCH));
    assign chk_fire    = wr_pulse ? (bus_wdata[OUT_W-1:0] & mode_q) : '0;

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (port_out == '0 && bus_rdata == '0));

    assert_rdata_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> (bus_rdata[DATA_W-1:OUT_W] == '0));

    assert_level_follows_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_latch |=> (((port_out ^ $past(bus_wdata[OUT_W-1:0])) & ~mode_q) == '0));

    assert_pulse_starts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_fire != '0) |=> ((port_out & $past(chk_fire)) == $past(chk_fire)));

    assert_strobe_spares_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> (((port_out ^ $past(port_out)) & ~mode_q & ~$past(mode_q)) == '0));

    assert_abort_shows_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mode |=> (((port_out ^ latch_q) & ~mode_q) == '0));

    assert_unmapped_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_unmapped |=> (bus_rdata == '0));
endmodule

bind pulse_latch_port pulse_latch_port_sva #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .OUT_W  (OUT_W)
) sva_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .port_out  (port_out),
    .mode_q    (mode_q),
    .latch_q   (latch_q)
);

// File: tb/pulse_latch_port_tb_top.sv
module pulse_latch_port_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PW   = 4;
    localparam int NB   = 24;
    localparam logic [5:0] A_MODE  = 6'd2;
    localparam logic [5:0] A_PULSE = 6'd3;
    localparam logic [5:0] A_LATCH = 6'd4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [23:0] port_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [23:0] mode_m = '0;
    logic [23:0] latch_m = '0;
    int          cnt_m [NB];
    logic [31:0] rd_exp;
    logic [23:0] out_exp;

    pulse_latch_port #(
        .ADDR_W (6), .DATA_W (32), .OUT_W (24), .PULSE_W (PW)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .bus_wr (bus_wr), .bus_rd (bus_rd),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata), .port_out (port_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=0x%06h exp=0x%06h", req, act, exp);
        end
    endtask

    // Model update for one clock edge, from the requirements.
    task automatic model_edge(input bit wr, input logic [5:0] a, input logic [31:0] d, input bit rd);
        logic [23:0] fired;
        if (rd) rd_exp = (a == A_MODE) ? {8'h0, mode_m} : (a == A_LATCH) ? {8'h0, latch_m} : 32'h0;
        fired = (wr && a == A_PULSE) ? (d[23:0] & mode_m) : '0;
        for (int i = 0; i < NB; i++) begin
            if (fired[i]) cnt_m[i] = PW;
            else if (cnt_m[i] > 0) cnt_m[i]--;
        end
        if (wr && a == A_MODE) begin
            mode_m = d[23:0];
            for (int i = 0; i < NB; i++) if (!mode_m[i]) cnt_m[i] = 0;
        end
        if (wr && a == A_LATCH) latch_m = d[23:0];
        for (int i = 0; i < NB; i++) out_exp[i] = mode_m[i] ? (cnt_m[i] > 0) : latch_m[i];
    endtask

    // Called at a falling edge; returns at the next falling edge after sampling.
    task automatic step(input bit wr, input logic [5:0] a, input logic [31:0] d, input bit rd);
        bus_wr = wr; bus_addr = a; bus_wdata = d; bus_rd = rd;
        @(posedge clk);
        model_edge(wr, a, d, rd);
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        chk("R3 R4 R6 model port_out", {8'h0, port_out}, {8'h0, out_exp});
        if (rd) chk("R2 R9 model bus_rdata", bus_rdata, rd_exp);
    endtask

    task automatic idle();
        step(1'b0, 6'd0, 32'h0, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired act=0 exp=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int hi;
        logic [31:0] lcg;
        for (int i = 0; i < NB; i++) cnt_m[i] = 0;
        out_exp = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 port_out in reset", {8'h0, port_out}, 32'h0);
        chk("R1 bus_rdata in reset", bus_rdata, 32'h0);
        rst_n = 1'b1;
        idle();
        chk("R1 port_out after reset", {8'h0, port_out}, 32'h0);
        step(1'b0, A_MODE, 32'h0, 1'b1);
        chk("R1 mode readback", bus_rdata, 32'h0);
        step(1'b0, A_LATCH, 32'h0, 1'b1);
        chk("R1 hold readback", bus_rdata, 32'h0);

        // R2: upper data bits dropped
        step(1'b1, A_LATCH, 32'hAB123456, 1'b0);
        step(1'b0, A_LATCH, 32'h0, 1'b1);
        chk("R2 hold readback", bus_rdata, 32'h00123456);
        step(1'b1, A_MODE, 32'hFF000000, 1'b0);
        step(1'b0, A_MODE, 32'h0, 1'b1);
        chk("R2 mode readback", bus_rdata, 32'h0);

        // R3: rise then fall on level bit 0
        step(1'b1, A_LATCH, 32'h0, 1'b0);
        step(1'b1, A_LATCH, 32'h1, 1'b0);
        chk("R3 rising edge", {31'h0, port_out[0]}, 32'h1);
        idle();
        chk("R3 held", {31'h0, port_out[0]}, 32'h1);
        step(1'b1, A_LATCH, 32'h0, 1'b0);
        chk("R3 falling edge", {31'h0, port_out[0]}, 32'h0);

        // R4: width of one pulse on bit 1
        step(1'b1, A_MODE, 32'h2, 1'b0);
        step(1'b1, A_PULSE, 32'h2, 1'b0);
        hi = int'(port_out[1]);
        for (int k = 0; k < 8; k++) begin idle(); hi += int'(port_out[1]); end
        chk("R4 pulse width", hi, PW);

        // R5: level bit and zero data bit do not pulse
        step(1'b1, A_PULSE, 32'h1, 1'b0);
        chk("R5 level bit strobed", {8'h0, port_out}, 32'h0);
        step(1'b1, A_PULSE, 32'hFFFFFD, 1'b0);
        chk("R5 zero data bit", {31'h0, port_out[1]}, 32'h0);

        // R6: pulse-mode bit ignores hold value
        step(1'b1, A_LATCH, 32'hFFFFFF, 1'b0);
        chk("R6 pulse bit ignores hold", {8'h0, port_out}, 32'hFFFFFD);
        step(1'b0, A_LATCH, 32'h0, 1'b1);
        chk("R6 hold still stored", bus_rdata, 32'h00FFFFFF);
        step(1'b1, A_LATCH, 32'h0, 1'b0);

        // R7: retrigger at the last high cycle and mid-pulse
        step(1'b1, A_PULSE, 32'h2, 1'b0);
        hi = 1;
        for (int k = 0; k < PW-1; k++) begin idle(); hi += int'(port_out[1]); end
        step(1'b1, A_PULSE, 32'h2, 1'b0);
        hi += int'(port_out[1]);
        for (int k = 0; k < PW+3; k++) begin idle(); hi += int'(port_out[1]); end
        chk("R7 retrigger at last cycle", hi, 2*PW);
        step(1'b1, A_PULSE, 32'h2, 1'b0);
        idle();
        step(1'b1, A_PULSE, 32'h2, 1'b0);
        hi = 3;
        for (int k = 0; k < PW+3; k++) begin idle(); hi += int'(port_out[1]); end
        chk("R7 retrigger mid pulse", hi, PW+2);

        // R8: abort a pulse by clearing mode
        step(1'b1, A_LATCH, 32'h2, 1'b0);
        step(1'b1, A_PULSE, 32'h2, 1'b0);
        step(1'b1, A_LATCH, 32'h0, 1'b0);
        step(1'b1, A_MODE, 32'h0, 1'b0);
        chk("R8 abort shows hold", {31'h0, port_out[1]}, 32'h0);
        step(1'b1, A_MODE, 32'h2, 1'b0);
        chk("R8 no resumed pulse", {31'h0, port_out[1]}, 32'h0);
        step(1'b1, A_LATCH, 32'h2, 1'b0);
        step(1'b1, A_PULSE, 32'h2, 1'b0);
        step(1'b1, A_MODE, 32'h0, 1'b0);
        chk("R8 abort to high hold", {31'h0, port_out[1]}, 32'h1);

        // R9: unmapped addresses
        step(1'b1, 6'd7, 32'hFFFFFFFF, 1'b0);
        step(1'b1, 6'd0, 32'hFFFFFFFF, 1'b0);
        step(1'b0, A_MODE, 32'h0, 1'b1);
        chk("R9 mode untouched", bus_rdata, 32'h0);
        step(1'b0, A_LATCH, 32'h0, 1'b1);
        chk("R9 hold untouched", bus_rdata, 32'h2);
        step(1'b0, 6'd5, 32'h0, 1'b1);
        chk("R9 unmapped read", bus_rdata, 32'h0);
        chk("R9 port unchanged", {8'h0, port_out}, 32'h2);

        // Sweep: each bit in turn, pseudo-random operation stream
        lcg = 32'h1234ABCD;
        for (int b = 0; b < NB; b++) begin
            for (int k = 0; k < 160; k++) begin
                logic [2:0] op;
                logic [31:0] dv;
                lcg = lcg * 32'd1664525 + 32'd1013904223;
                op = lcg[30:28];
                dv = {lcg[7:0], (lcg[27:4] & 24'hF0F0F0) | (24'h1 << b)};
                if (lcg[3]) dv[23:0] = dv[23:0] & ~(24'h1 << b);
                case (op)
                    3'd0: step(1'b1, A_MODE,  dv, 1'b0);
                    3'd1, 3'd2: step(1'b1, A_PULSE, dv, 1'b0);
                    3'd3: step(1'b1, A_LATCH, dv, 1'b0);
                    3'd4: step(1'b0, lcg[2] ? A_MODE : A_LATCH, 32'h0, 1'b1);
                    3'd5: step(1'b1, 6'(lcg[13:8]), dv, 1'b0);
                    default: idle();
                endcase
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule